// File: doc/BRIEF.md
# Segmented Linear Address Generator

This block forms memory addresses for a processor core that can run with 16-, 32- or 64-bit address sizes. Each request carries a base register value, an optional index register value with a 2-bit scale code, a displacement and an address-size code. The block adds these parts to form the effective address and cuts that sum down to the selected address size. It then adds a segment base at full 64-bit width to give the linear address. The segment base is applied only when the request flags one of the two extra segments that may have a non-zero base. In every other case the address space is flat and the linear address equals the effective address.

A request is accepted on any cycle in which `in_valid` is high. The results appear on registered outputs one cycle later, together with `out_valid`. There is no backpressure. An unused address-size code raises an error flag and yields zero addresses.

The block also holds a 64-bit instruction pointer register with a write port. A write merges the new value into the register according to the operand size. A 16-bit write keeps the upper bits. A 32-bit write clears the upper half. A 64-bit write replaces the whole register.

Top module: `seg_lin_agu`

## Requirements
- R1: With `addr_mode` = 2'b10 (64-bit), `eff_addr` equals base + scaled index + extended displacement, taken modulo 2^64.
- R2: `scale_sel` values 2'b00, 2'b01, 2'b10 and 2'b11 multiply the index by 1, 2, 4 and 8. When `index_used` is 0 the index adds nothing, whatever its value.
- R3: When `disp_wide` = 0, bits 31:0 of `disp_val` are sign-extended to 64 bits and bits 63:32 are ignored. When `disp_wide` = 1, all 64 bits of `disp_val` are used.
- R4: With `addr_mode` = 2'b00 the full sum is cut to bits 15:0, and with 2'b01 it is cut to bits 31:0. In both cases the cut value is zero-extended to form `eff_addr`.
- R5: When `seg_base_en` = 1, `lin_addr` = `eff_addr` + `seg_base`, taken modulo 2^64. The base is never truncated, so the carry above the selected address size is kept.
- R6: When `seg_base_en` = 0, `lin_addr` equals `eff_addr` whatever the value on `seg_base`.
- R7: With `addr_mode` = 2'b11, `mode_err` is 1 and both `eff_addr` and `lin_addr` are 0. For any other code, `mode_err` is 0.
- R8: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. While `in_valid` is low, `eff_addr`, `lin_addr` and `mode_err` hold their values.
- R9: A synchronous active-high `rst` clears `out_valid` and `ip_q` to 0.
- R10: A write with `ip_wr` = 1 and `ip_size` = 2'b00 loads `ip_wdata[15:0]` into `ip_q[15:0]` and leaves `ip_q[63:16]` unchanged.
- R11: A write with `ip_size` = 2'b01 loads bits 31:0 and clears bits 63:32. A write with `ip_size` = 2'b10 loads all 64 bits.
- R12: When `ip_wr` = 0, or when `ip_size` = 2'b11, `ip_q` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Address request valid |
| base_val | input | 64 | Base register value |
| index_val | input | 64 | Index register value |
| index_used | input | 1 | Index register participates |
| scale_sel | input | 2 | Index scale code (x1, x2, x4, x8) |
| disp_val | input | 64 | Displacement; only the low 32 bits are used unless wide |
| disp_wide | input | 1 | Use the full 64-bit displacement |
| addr_mode | input | 2 | Address size: 00=16, 01=32, 10=64, 11=reserved |
| seg_base | input | 64 | Segment base address |
| seg_base_en | input | 1 | Apply the segment base (extra segment selected) |
| out_valid | output | 1 | Result valid |
| eff_addr | output | 64 | Effective address, truncated and zero-extended |
| lin_addr | output | 64 | Linear address |
| mode_err | output | 1 | Reserved address-size code was used |
| ip_wr | input | 1 | Instruction pointer write enable |
| ip_size | input | 2 | Pointer write size: 00=16, 01=32, 10=64, 11=no write |
| ip_wdata | input | 64 | New pointer value |
| ip_q | output | 64 | Instruction pointer register |

## Verification
Some properties are checked by the assertions on every cycle. These are the upper-zero rule for 16- and 32-bit results, the zero result and error flag for the reserved code, the flat-segment equality, the one-cycle valid timing with held outputs, and every pointer merge rule. Only the bench's scenarios can show that the sums themselves are right. That covers scale factors, sign extension of negative displacements, wrap inside a narrow address size, and a segment base that carries beyond that size or wraps past 2^64. The bench compares these against hand-derived vectors.

// File: rtl/agu_pkg.sv
package agu_pkg;

   typedef enum logic [1:0] {
      ASZ_16  = 2'b00,
      ASZ_32  = 2'b01,
      ASZ_64  = 2'b10,
      ASZ_RSV = 2'b11
   } asz_e;

   localparam int unsigned NARROW_W = 16;
   localparam int unsigned MID_W    = 32;

   function automatic logic asz_is_reserved(input logic [1:0] code);
      return (code == ASZ_RSV);
   endfunction

endpackage

// File: rtl/agu_index_scale.sv
module agu_index_scale #(
   parameter int unsigned XLEN    = 64,
   parameter int unsigned SCALE_W = 2
) (
   input  logic [XLEN-1:0]    index_val,
   input  logic               index_used,
   input  logic [SCALE_W-1:0] scale_sel,
   output logic [XLEN-1:0]    scaled_idx
);
   localparam int unsigned NSCALE = 1 << SCALE_W;

   if (SCALE_W < 1 || SCALE_W > 3) begin : g_bad_scale
      $error("agu_index_scale: SCALE_W must be 1..3");
   end

   logic [XLEN-1:0] cand [NSCALE];

   for (genvar k = 0; k < NSCALE; k++) begin : g_shift
      assign cand[k] = index_val << k;
   end

   always_comb begin
      if (index_used) begin
         scaled_idx = cand[scale_sel];
      end else begin
         scaled_idx = '0;
      end
   end
endmodule

// File: rtl/agu_disp_ext.sv
module agu_disp_ext #(
   parameter int unsigned XLEN   = 64,
   parameter int unsigned DISP_W = 32
) (
   input  logic [XLEN-1:0] disp_val,
   input  logic            disp_wide,
   output logic [XLEN-1:0] disp_ext
);
   localparam int unsigned PAD_W = XLEN - DISP_W;

   if (DISP_W < 8 || DISP_W >= XLEN) begin : g_bad_disp
      $error("agu_disp_ext: DISP_W must be at least 8 and below XLEN");
   end

   logic [XLEN-1:0] short_ext;

   assign short_ext = {{PAD_W{disp_val[DISP_W-1]}}, disp_val[DISP_W-1:0]};

   always_comb begin
      if (disp_wide) begin
         disp_ext = disp_val;
      end else begin
         disp_ext = short_ext;
      end
   end
endmodule

// File: rtl/agu_ea_trunc.sv
module agu_ea_trunc
   import agu_pkg::*;
#(
   parameter int unsigned XLEN = 64
) (
   input  logic [XLEN-1:0] base_val,
   input  logic [XLEN-1:0] scaled_idx,
   input  logic [XLEN-1:0] disp_ext,
   input  logic [1:0]      addr_mode,
   output logic [XLEN-1:0] eff_addr,
   output logic            bad_mode
);
   localparam int unsigned HI16_W = XLEN - NARROW_W;
   localparam int unsigned HI32_W = XLEN - MID_W;

   if (XLEN <= MID_W) begin : g_bad_xlen
      $error("agu_ea_trunc: XLEN must exceed 32");
   end

   logic [XLEN-1:0] raw_sum;
   logic [XLEN-1:0] mask16;
   logic [XLEN-1:0] mask32;

   assign raw_sum = base_val + scaled_idx + disp_ext;
   assign mask16  = {{HI16_W{1'b0}}, {NARROW_W{1'b1}}};
   assign mask32  = {{HI32_W{1'b0}}, {MID_W{1'b1}}};

   always_comb begin
      bad_mode = asz_is_reserved(addr_mode);
      unique case (addr_mode)
         ASZ_16:  eff_addr = raw_sum & mask16;
         ASZ_32:  eff_addr = raw_sum & mask32;
         ASZ_64:  eff_addr = raw_sum;
         default: eff_addr = '0;
      endcase
   end
endmodule

// File: rtl/agu_seg_add.sv
module agu_seg_add #(
   parameter int unsigned XLEN = 64
) (
   input  logic [XLEN-1:0] eff_addr,
   input  logic [XLEN-1:0] seg_base,
   input  logic            seg_base_en,
   input  logic            bad_mode,
   output logic [XLEN-1:0] lin_addr
);
   logic [XLEN-1:0] applied_base;

   assign applied_base = seg_base_en ? seg_base : '0;

   always_comb begin
      if (bad_mode) begin
         lin_addr = '0;
      end else begin
         lin_addr = eff_addr + applied_base;
      end
   end
endmodule

// File: rtl/agu_ip_merge.sv
module agu_ip_merge
   import agu_pkg::*;
#(
   parameter int unsigned XLEN = 64
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            ip_wr,
   input  logic [1:0]      ip_size,
   input  logic [XLEN-1:0] ip_wdata,
   output logic [XLEN-1:0] ip_q
);
   localparam int unsigned HI32_W = XLEN - MID_W;

   logic [XLEN-1:0] ip_r;

   always_ff @(posedge clk) begin
      if (rst) begin
         ip_r <= '0;
      end else if (ip_wr) begin
         unique case (ip_size)
            ASZ_16:  ip_r[NARROW_W-1:0] <= ip_wdata[NARROW_W-1:0];
            ASZ_32:  ip_r <= {{HI32_W{1'b0}}, ip_wdata[MID_W-1:0]};
            ASZ_64:  ip_r <= ip_wdata;
            default: ip_r <= ip_r;
         endcase
      end
   end

   assign ip_q = ip_r;

   AST_IP16_KEEP_HI: assert property (@(posedge clk) disable iff (rst)
      (ip_wr && ip_size == ASZ_16) |=> (ip_q[XLEN-1:NARROW_W] == $past(ip_q[XLEN-1:NARROW_W]))); // R10
   AST_IP16_LOAD_LO: assert property (@(posedge clk) disable iff (rst)
      (ip_wr && ip_size == ASZ_16) |=> (ip_q[NARROW_W-1:0] == $past(ip_wdata[NARROW_W-1:0]))); // R10
   AST_IP32_CLEAR_HI: assert property (@(posedge clk) disable iff (rst)
      (ip_wr && ip_size == ASZ_32) |=> (ip_q[XLEN-1:MID_W] == '0)); // R11
   AST_IP64_FULL: assert property (@(posedge clk) disable iff (rst)
      (ip_wr && ip_size == ASZ_64) |=> (ip_q == $past(ip_wdata))); // R11
   AST_IP_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!ip_wr || ip_size == ASZ_RSV) |=> $stable(ip_q)); // R12
endmodule

// File: rtl/seg_lin_agu.sv
module seg_lin_agu
   import agu_pkg::*;
#(
   parameter int unsigned XLEN    = 64,
   parameter int unsigned DISP_W  = 32,
   parameter int unsigned SCALE_W = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               in_valid,
   input  logic [XLEN-1:0]    base_val,
   input  logic [XLEN-1:0]    index_val,
   input  logic               index_used,
   input  logic [SCALE_W-1:0] scale_sel,
   input  logic [XLEN-1:0]    disp_val,
   input  logic               disp_wide,
   input  logic [1:0]         addr_mode,
   input  logic [XLEN-1:0]    seg_base,
   input  logic               seg_base_en,
   output logic               out_valid,
   output logic [XLEN-1:0]    eff_addr,
   output logic [XLEN-1:0]    lin_addr,
   output logic               mode_err,
   input  logic               ip_wr,
   input  logic [1:0]         ip_size,
   input  logic [XLEN-1:0]    ip_wdata,
   output logic [XLEN-1:0]    ip_q
);
   localparam int unsigned HI16_W = XLEN - NARROW_W;
   localparam int unsigned HI32_W = XLEN - MID_W;

   logic [XLEN-1:0] scaled_idx;
   logic [XLEN-1:0] disp_ext;
   logic [XLEN-1:0] ea_c;
   logic [XLEN-1:0] lin_c;
   logic            bad_c;

   logic            vld_q;
   logic [XLEN-1:0] ea_q;
   logic [XLEN-1:0] lin_q;
   logic            err_q;
   logic [1:0]      mode_q;
   logic            segen_q;

   agu_index_scale #(.XLEN(XLEN), .SCALE_W(SCALE_W)) u_scale (
      .index_val  (index_val),
      .index_used (index_used),
      .scale_sel  (scale_sel),
      .scaled_idx (scaled_idx)
   );

   agu_disp_ext #(.XLEN(XLEN), .DISP_W(DISP_W)) u_disp (
      .disp_val  (disp_val),
      .disp_wide (disp_wide),
      .disp_ext  (disp_ext)
   );

   agu_ea_trunc #(.XLEN(XLEN)) u_ea (
      .base_val   (base_val),
      .scaled_idx (scaled_idx),
      .disp_ext   (disp_ext),
      .addr_mode  (addr_mode),
      .eff_addr   (ea_c),
      .bad_mode   (bad_c)
   );

   agu_seg_add #(.XLEN(XLEN)) u_seg (
      .eff_addr    (ea_c),
      .seg_base    (seg_base),
      .seg_base_en (seg_base_en),
      .bad_mode    (bad_c),
      .lin_addr    (lin_c)
   );

   agu_ip_merge #(.XLEN(XLEN)) u_ip (
      .clk      (clk),
      .rst      (rst),
      .ip_wr    (ip_wr),
      .ip_size  (ip_size),
      .ip_wdata (ip_wdata),
      .ip_q     (ip_q)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q   <= 1'b0;
         ea_q    <= '0;
         lin_q   <= '0;
         err_q   <= 1'b0;
         mode_q  <= ASZ_64;
         segen_q <= 1'b0;
      end else begin
         vld_q <= in_valid;
         if (in_valid) begin
            ea_q    <= ea_c;
            lin_q   <= lin_c;
            err_q   <= bad_c;
            mode_q  <= addr_mode;
            segen_q <= seg_base_en;
         end
      end
   end

   assign out_valid = vld_q;
   assign eff_addr  = ea_q;
   assign lin_addr  = lin_q;
   assign mode_err  = err_q;

   AST_EA16_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
      (out_valid && mode_q == ASZ_16) |-> (eff_addr[XLEN-1:NARROW_W] == {HI16_W{1'b0}})); // R4
   AST_EA32_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
      (out_valid && mode_q == ASZ_32) |-> (eff_addr[XLEN-1:MID_W] == {HI32_W{1'b0}})); // R4
   AST_FLAT_EQUAL: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !segen_q) |-> (lin_addr == eff_addr)); // R6
   AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
      (out_valid && mode_err) |-> (eff_addr == '0 && lin_addr == '0)); // R7
   AST_ERR_ONLY_RSV: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (mode_err == (mode_q == ASZ_RSV))); // R7
   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid); // R8
   AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid); // R8
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(eff_addr) && $stable(lin_addr) && $stable(mode_err))); // R8
endmodule

// File: tb/seg_lin_agu_tb_top.sv
`timescale 1ns/1ps
module seg_lin_agu_tb_top;

   typedef struct packed {
      logic [63:0] base;
      logic [63:0] index;
      logic        used;
      logic [1:0]  scale;
      logic [63:0] disp;
      logic        wide;
      logic [1:0]  mode;
      logic [63:0] seg;
      logic        seg_en;
      logic [63:0] exp_eff;
      logic [63:0] exp_lin;
      logic        exp_err;
   } vec_t;

   localparam int NVEC = 10;
   localparam vec_t VECS [NVEC] = '{
      // R1 64-bit sum with x8 index
      '{64'h0000_0001_0000_0000, 64'h10, 1'b1, 2'b11, 64'h4, 1'b0, 2'b10, 64'h0, 1'b0,
        64'h0000_0001_0000_0084, 64'h0000_0001_0000_0084, 1'b0},
      // R3 negative short displacement, upper disp bits ignored, x2 index (R2)
      '{64'h1000, 64'h100, 1'b1, 2'b01, 64'hABCD_0000_FFFF_FFF0, 1'b0, 2'b10, 64'h0, 1'b0,
        64'h11F0, 64'h11F0, 1'b0},
      // R2 index not used
      '{64'h2000, 64'hFFFF, 1'b0, 2'b11, 64'h10, 1'b0, 2'b10, 64'h0, 1'b0,
        64'h2010, 64'h2010, 1'b0},
      // R4 16-bit wrap, R5 base added after truncation
      '{64'hFFF0, 64'h20, 1'b1, 2'b00, 64'h0, 1'b0, 2'b00, 64'h1_0000, 1'b1,
        64'h10, 64'h1_0010, 1'b0},
      // R4 32-bit wrap, R5 base kept at full width
      '{64'hFFFF_FFF0, 64'h8, 1'b1, 2'b01, 64'h8, 1'b0, 2'b01, 64'hFFFF_FFFF_0000_0000, 1'b1,
        64'h8, 64'hFFFF_FFFF_0000_0008, 1'b0},
      // R3 wide displacement
      '{64'h10, 64'h0, 1'b0, 2'b00, 64'h1234_5678_0000_0000, 1'b1, 2'b10, 64'h0, 1'b0,
        64'h1234_5678_0000_0010, 64'h1234_5678_0000_0010, 1'b0},
      // R6 flat: base ignored when not enabled
      '{64'h100, 64'h0, 1'b0, 2'b00, 64'h0, 1'b0, 2'b01, 64'hDEAD_BEEF_0000_0000, 1'b0,
        64'h100, 64'h100, 1'b0},
      // R7 reserved size code
      '{64'h55, 64'h1, 1'b1, 2'b00, 64'h1, 1'b0, 2'b11, 64'h1000, 1'b1,
        64'h0, 64'h0, 1'b1},
      // R5 linear wrap past 2^64
      '{64'hFFFF_FFFF_FFFF_FFF0, 64'h0, 1'b0, 2'b00, 64'h0, 1'b0, 2'b10, 64'h20, 1'b1,
        64'hFFFF_FFFF_FFFF_FFF0, 64'h10, 1'b0},
      // R4 32-bit truncation of a negative sum
      '{64'h10, 64'h0, 1'b0, 2'b00, 64'hFFFF_FFE0, 1'b0, 2'b01, 64'h0, 1'b0,
        64'hFFFF_FFF0, 64'hFFFF_FFF0, 1'b0}
   };

   function automatic string vtag(input int i);
      case (i)
         0: return "R1";
         1: return "R3";
         2: return "R2";
         3: return "R4";
         4: return "R5";
         5: return "R3";
         6: return "R6";
         7: return "R7";
         8: return "R5";
         default: return "R4";
      endcase
   endfunction

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [63:0] base_val;
   logic [63:0] index_val;
   logic        index_used;
   logic [1:0]  scale_sel;
   logic [63:0] disp_val;
   logic        disp_wide;
   logic [1:0]  addr_mode;
   logic [63:0] seg_base;
   logic        seg_base_en;
   logic        out_valid;
   logic [63:0] eff_addr;
   logic [63:0] lin_addr;
   logic        mode_err;
   logic        ip_wr;
   logic [1:0]  ip_size;
   logic [63:0] ip_wdata;
   logic [63:0] ip_q;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   seg_lin_agu dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid),
      .base_val(base_val), .index_val(index_val), .index_used(index_used),
      .scale_sel(scale_sel), .disp_val(disp_val), .disp_wide(disp_wide),
      .addr_mode(addr_mode), .seg_base(seg_base), .seg_base_en(seg_base_en),
      .out_valid(out_valid), .eff_addr(eff_addr), .lin_addr(lin_addr),
      .mode_err(mode_err), .ip_wr(ip_wr), .ip_size(ip_size),
      .ip_wdata(ip_wdata), .ip_q(ip_q)
   );

   task automatic chk(input string tag, input string what, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic ip_write(input logic [1:0] sz, input logic [63:0] d, input logic en);
      ip_wr    = en;
      ip_size  = sz;
      ip_wdata = d;
      step();
      ip_wr = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; in_valid = 1'b0;
      base_val = '0; index_val = '0; index_used = 1'b0; scale_sel = '0;
      disp_val = '0; disp_wide = 1'b0; addr_mode = 2'b10;
      seg_base = '0; seg_base_en = 1'b0;
      ip_wr = 1'b0; ip_size = 2'b10; ip_wdata = '0;
      @(negedge clk);
      step();
      step();
      chk("R9", "out_valid after reset", {63'd0, out_valid}, 64'd0);
      chk("R9", "ip_q after reset", ip_q, 64'd0);
      rst = 1'b0;
      step();

      for (int i = 0; i < NVEC; i++) begin
         in_valid    = 1'b1;
         base_val    = VECS[i].base;
         index_val   = VECS[i].index;
         index_used  = VECS[i].used;
         scale_sel   = VECS[i].scale;
         disp_val    = VECS[i].disp;
         disp_wide   = VECS[i].wide;
         addr_mode   = VECS[i].mode;
         seg_base    = VECS[i].seg;
         seg_base_en = VECS[i].seg_en;
         step();
         chk("R8", $sformatf("vec %0d out_valid", i), {63'd0, out_valid}, 64'd1);
         chk(vtag(i), $sformatf("vec %0d eff_addr", i), eff_addr, VECS[i].exp_eff);
         chk(vtag(i), $sformatf("vec %0d lin_addr", i), lin_addr, VECS[i].exp_lin);
         chk("R7", $sformatf("vec %0d mode_err", i), {63'd0, mode_err}, {63'd0, VECS[i].exp_err});
      end

      // R8: idle cycle drops out_valid and holds the last result
      in_valid  = 1'b0;
      base_val  = 64'h7777;
      addr_mode = 2'b00;
      step();
      chk("R8", "out_valid idle", {63'd0, out_valid}, 64'd0);
      chk("R8", "eff_addr held idle", eff_addr, 64'hFFFF_FFF0);
      chk("R8", "lin_addr held idle", lin_addr, 64'hFFFF_FFF0);

      // R2: x4 scale, 16-bit mode
      in_valid = 1'b1; base_val = 64'h1; index_val = 64'h3; index_used = 1'b1;
      scale_sel = 2'b10; disp_val = 64'h0; disp_wide = 1'b0; addr_mode = 2'b00;
      seg_base_en = 1'b0;
      step();
      chk("R2", "x4 scale eff_addr", eff_addr, 64'hD);
      in_valid = 1'b0;

      // R11 64-bit write, R10 16-bit merge, R11 32-bit clear, R12 ignored writes
      ip_write(2'b10, 64'h1111_2222_3333_4444, 1'b1);
      chk("R11", "ip 64-bit write", ip_q, 64'h1111_2222_3333_4444);
      ip_write(2'b00, 64'hAAAA_BBBB_CCCC_DDDD, 1'b1);
      chk("R10", "ip 16-bit merge", ip_q, 64'h1111_2222_3333_DDDD);
      ip_write(2'b11, 64'h0, 1'b1);
      chk("R12", "ip reserved size", ip_q, 64'h1111_2222_3333_DDDD);
      ip_write(2'b10, 64'h5, 1'b0);
      chk("R12", "ip no write enable", ip_q, 64'h1111_2222_3333_DDDD);
      ip_write(2'b01, 64'hFFFF_FFFF_8765_4321, 1'b1);
      chk("R11", "ip 32-bit write", ip_q, 64'h0000_0000_8765_4321);

      // R9: reset mid-run clears valid and the pointer
      in_valid = 1'b1;
      rst = 1'b1;
      step();
      chk("R9", "out_valid under reset", {63'd0, out_valid}, 64'd0);
      chk("R9", "ip_q under reset", ip_q, 64'd0);
      rst = 1'b0;
      in_valid = 1'b0;
      step();

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule